// File: doc/BRIEF.md
# Tracking Mode Controller for a Timing-Source Digital PLL

This block decides which operating mode the digital PLL of a network timing source is in. Every cycle it looks at status flags from the reference selector (a reference is selected, the selected one is qualified, any qualified reference exists, the selection has just switched) and at the lock detector. An automatic state machine walks through seven tracking modes: free-run, two transient pre-lock states, locked, lost-phase, holdover and a DCO write mode. A 5-bit control word can instead force any one of these modes. Codes that the control word does not define hold the present mode.

Besides the mode code, the block produces a loop-stage selector. It picks one of three parameterised bandwidth/damping sets. The start set applies for the first few seconds after each entry into a pre-lock state, counted on an external seconds tick. The acquisition set applies after that until lock. The locked set applies while locked. Every mode change sets a sticky flag. The interrupt line is that flag gated by a mask input.

All pins are plain control and status levels sampled on the clock. The block has no streaming data path, so it has no valid/ready handshake and no back-pressure.

Top module: `dpll_mode_ctrl`

## Requirements
- R1: After reset the mode code is 00001 (free-run), the sticky change flag and the interrupt are 0, and the loop stage is acquisition (01).
- R2: With control word 00001, 00010, 00100, 00101, 00110, 00111 or 01000, the mode code equals that word one clock later, whatever the status inputs are. 00010 is holdover, 00100 locked, 00101 pre-locked2, 00110 pre-locked, 00111 lost-phase and 01000 DCO write.
- R3: Any control word other than 00000 and the seven codes of R2 leaves the mode code unchanged.
- R4: With control word 00000 (automatic), free-run or DCO write moves to pre-locked (00110) on the clock after ref_sel is 1.
- R5: In automatic mode, pre-locked, pre-locked2 or lost-phase moves to holdover (00010) when ref_qual and any_qual are both 0. This takes priority over lock_ind.
- R6: In automatic mode, pre-locked and pre-locked2 move to locked (00100) when lock_ind is 1.
- R7: In automatic mode, locked moves to lost-phase when lock_ind is 0, and lost-phase moves back to locked when lock_ind is 1.
- R8: In automatic mode, locked, lost-phase and holdover move to pre-locked2 (00101) when ref_switch is 1. Holdover also does so when ref_sel and ref_qual are both 1.
- R9: Every change of the mode code sets mode_chg, which stays 1 until chg_clr is 1 in a cycle with no mode change. A new change wins over a clear in the same cycle.
- R10: irq is 1 exactly when mode_chg is 1 and irq_mask is 1.
- R11: loop_stage is start (00) in pre-locked or pre-locked2 until START_SECS sec_tick pulses have been counted since entry. It is locked (10) in locked mode and acquisition (01) otherwise.
- R12: bw_code and damp_code carry the parameter set of the current loop stage (defaults: start 20/5, acquisition 12/3, locked 4/1).
- R13: The start window restarts on every entry into pre-locked or pre-locked2, including re-entry from locked on a reference switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_sel | input | 1 | A reference is currently selected |
| ref_qual | input | 1 | The selected reference is qualified |
| any_qual | input | 1 | At least one qualified reference exists |
| ref_switch | input | 1 | Selection moved to another reference this cycle |
| lock_ind | input | 1 | Lock detector output |
| sec_tick | input | 1 | One-cycle pulse per second |
| mode_ctrl | input | 5 | Mode control word |
| irq_mask | input | 1 | Interrupt enable for the change flag |
| chg_clr | input | 1 | Clears the sticky change flag |
| mode_code | output | 5 | Current mode code |
| mode_chg | output | 1 | Sticky mode-change flag |
| irq | output | 1 | Interrupt request |
| loop_stage | output | 2 | Loop stage: 00 start, 01 acquisition, 10 locked |
| bw_code | output | 5 | Selected bandwidth code |
| damp_code | output | 3 | Selected damping code |

## Verification
Some rules are checked by assertions on every cycle: forced codes land one clock later, reserved codes freeze the mode, and a mode change always leaves the sticky flag set. The assertions also check that a masked interrupt never fires, that locked mode always selects the locked loop stage, and that disqualification in a pre-lock state goes to holdover. The bench scenarios are the only place where the full automatic path is shown: free-run through pre-locked, locked, lost-phase and back, then a reference switch into pre-locked2. Only the bench shows the start window counting seconds ticks and restarting on re-entry, and the exact bandwidth and damping values in each stage.

// File: rtl/dpll_mode_pkg.sv
package dpll_mode_pkg;
  typedef enum logic [4:0] {
    M_FREE = 5'b00001,
    M_HOLD = 5'b00010,
    M_LOCK = 5'b00100,
    M_PRE2 = 5'b00101,
    M_PRE  = 5'b00110,
    M_LOST = 5'b00111,
    M_DCO  = 5'b01000
  } mode_t;

  typedef enum logic [1:0] {
    ST_START = 2'b00,
    ST_ACQ   = 2'b01,
    ST_LOCK  = 2'b10
  } stage_t;

  localparam logic [4:0] CTRL_AUTO = 5'b00000;
endpackage

// File: rtl/dpll_mode_fsm.sv
module dpll_mode_fsm
  import dpll_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_sel,
  input  logic       ref_qual,
  input  logic       any_qual,
  input  logic       ref_switch,
  input  logic       lock_ind,
  input  logic [4:0] mode_ctrl,
  output mode_t      mode_q,
  output logic       changed,
  output logic       enter_pre
);
  mode_t auto_nxt, nxt;
  logic  ref_lost;

  assign ref_lost = !ref_qual && !any_qual;

  always_comb begin
    auto_nxt = mode_q;
    unique case (mode_q)
      M_FREE, M_DCO: if (ref_sel) auto_nxt = M_PRE;
      M_PRE, M_PRE2: begin
        if (ref_lost)      auto_nxt = M_HOLD;
        else if (lock_ind) auto_nxt = M_LOCK;
      end
      M_LOST: begin
        if (ref_lost)        auto_nxt = M_HOLD;
        else if (ref_switch) auto_nxt = M_PRE2;
        else if (lock_ind)   auto_nxt = M_LOCK;
      end
      M_LOCK: begin
        if (ref_switch)     auto_nxt = M_PRE2;
        else if (!lock_ind) auto_nxt = M_LOST;
      end
      M_HOLD: if (ref_switch || (ref_sel && ref_qual)) auto_nxt = M_PRE2;
      default: auto_nxt = M_FREE;
    endcase
  end

  always_comb begin
    case (mode_ctrl)
      CTRL_AUTO: nxt = auto_nxt;
      5'b00001, 5'b00010, 5'b00100, 5'b00101,
      5'b00110, 5'b00111, 5'b01000: nxt = mode_t'(mode_ctrl);
      default: nxt = mode_q;
    endcase
  end

  assign changed   = (nxt != mode_q);
  assign enter_pre = changed && (nxt == M_PRE || nxt == M_PRE2);

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= M_FREE;
    else        mode_q <= nxt;
  end
endmodule

// File: rtl/dpll_start_timer.sv
module dpll_start_timer
  import dpll_mode_pkg::*;
#(
  parameter int START_SECS = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  mode_t mode_q,
  input  logic  enter_pre,
  input  logic  sec_tick,
  output logic  in_window
);
  localparam int CW = $clog2(START_SECS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(START_SECS);

  logic [CW-1:0] secs_q;
  logic          pre_mode;

  assign pre_mode  = (mode_q == M_PRE) || (mode_q == M_PRE2);
  assign in_window = pre_mode && (secs_q < LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n)                             secs_q <= '0;
    else if (enter_pre)                     secs_q <= '0;
    else if (pre_mode && sec_tick && secs_q < LIMIT) secs_q <= secs_q + 1'b1;
  end
endmodule

// File: rtl/dpll_chg_irq.sv
module dpll_chg_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic changed,
  input  logic chg_clr,
  input  logic irq_mask,
  output logic sticky_q,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)       sticky_q <= 1'b0;
    else if (changed) sticky_q <= 1'b1;
    else if (chg_clr) sticky_q <= 1'b0;
  end

  assign irq = sticky_q && irq_mask;
endmodule

// File: rtl/dpll_mode_ctrl.sv
module dpll_mode_ctrl
  import dpll_mode_pkg::*;
#(
  parameter int         START_SECS = 2,
  parameter logic [4:0] BW_START   = 5'd20,
  parameter logic [4:0] BW_ACQ     = 5'd12,
  parameter logic [4:0] BW_LOCK    = 5'd4,
  parameter logic [2:0] DAMP_START = 3'd5,
  parameter logic [2:0] DAMP_ACQ   = 3'd3,
  parameter logic [2:0] DAMP_LOCK  = 3'd1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_sel,
  input  logic       ref_qual,
  input  logic       any_qual,
  input  logic       ref_switch,
  input  logic       lock_ind,
  input  logic       sec_tick,
  input  logic [4:0] mode_ctrl,
  input  logic       irq_mask,
  input  logic       chg_clr,
  output logic [4:0] mode_code,
  output logic       mode_chg,
  output logic       irq,
  output logic [1:0] loop_stage,
  output logic [4:0] bw_code,
  output logic [2:0] damp_code
);
  mode_t  mode_q;
  logic   changed, enter_pre, in_window;
  stage_t stage;

  dpll_mode_fsm u_fsm (
    .clk, .rst_n, .ref_sel, .ref_qual, .any_qual, .ref_switch, .lock_ind,
    .mode_ctrl, .mode_q, .changed, .enter_pre
  );

  dpll_start_timer #(.START_SECS(START_SECS)) u_timer (
    .clk, .rst_n, .mode_q, .enter_pre, .sec_tick, .in_window
  );

  dpll_chg_irq u_irq (
    .clk, .rst_n, .changed, .chg_clr, .irq_mask, .sticky_q(mode_chg), .irq
  );

  always_comb begin
    if (mode_q == M_LOCK) stage = ST_LOCK;
    else if (in_window)   stage = ST_START;
    else                  stage = ST_ACQ;
  end

  always_comb begin
    unique case (stage)
      ST_START: begin bw_code = BW_START; damp_code = DAMP_START; end
      ST_LOCK:  begin bw_code = BW_LOCK;  damp_code = DAMP_LOCK;  end
      default:  begin bw_code = BW_ACQ;   damp_code = DAMP_ACQ;   end
    endcase
  end

  assign mode_code  = mode_q;
  assign loop_stage = stage;
endmodule

// File: rtl/dpll_mode_ctrl_chk.sv
module dpll_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ref_qual,
  input logic       any_qual,
  input logic [4:0] mode_ctrl,
  input logic       irq_mask,
  input logic [4:0] mode_code,
  input logic       mode_chg,
  input logic       irq,
  input logic [1:0] loop_stage
);
  logic forced, reserved;
  assign forced = (mode_ctrl == 5'b00001) || (mode_ctrl == 5'b00010) ||
                  (mode_ctrl == 5'b00100) || (mode_ctrl == 5'b00101) ||
                  (mode_ctrl == 5'b00110) || (mode_ctrl == 5'b00111) ||
                  (mode_ctrl == 5'b01000);
  assign reserved = !forced && (mode_ctrl != 5'b00000);

  AST_FORCED_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    forced |=> mode_code == $past(mode_ctrl)); // R2
  AST_RESERVED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    reserved |=> $stable(mode_code)); // R3
  AST_DISQUAL_HOLDOVER: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_ctrl == 5'b00000 && (mode_code == 5'b00110 || mode_code == 5'b00101)
     && !ref_qual && !any_qual) |=> mode_code == 5'b00010); // R5
  AST_CHANGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_code) |-> mode_chg); // R9
  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_mask |-> !irq); // R10
  AST_LOCK_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_code == 5'b00100 |-> loop_stage == 2'b10); // R11
endmodule

bind dpll_mode_ctrl dpll_mode_ctrl_chk u_chk (
  .clk, .rst_n, .ref_qual, .any_qual, .mode_ctrl, .irq_mask,
  .mode_code, .mode_chg, .irq, .loop_stage
);

// File: tb/dpll_mode_ctrl_tb_top.sv
module dpll_mode_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_sel = 0, ref_qual = 0, any_qual = 0, ref_switch = 0, lock_ind = 0;
  logic sec_tick = 0, irq_mask = 0, chg_clr = 0;
  logic [4:0] mode_ctrl = 5'b00000;
  logic [4:0] mode_code, bw_code;
  logic mode_chg, irq;
  logic [1:0] loop_stage;
  logic [2:0] damp_code;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  dpll_mode_ctrl dut_i (
    .clk, .rst_n, .ref_sel, .ref_qual, .any_qual, .ref_switch, .lock_ind,
    .sec_tick, .mode_ctrl, .irq_mask, .chg_clr, .mode_code, .mode_chg, .irq,
    .loop_stage, .bw_code, .damp_code
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk_stage(input string req, input logic [1:0] st);
    chk(req, 32'(loop_stage), 32'(st));
    case (st)
      2'b00: begin chk(req, 32'(bw_code), 20); chk(req, 32'(damp_code), 5); end
      2'b10: begin chk(req, 32'(bw_code), 4);  chk(req, 32'(damp_code), 1); end
      default: begin chk(req, 32'(bw_code), 12); chk(req, 32'(damp_code), 3); end
    endcase
  endtask

  task automatic t_reset();
    rst_n = 0; step(); step(); rst_n = 1; #1;
    chk("R1 mode", 32'(mode_code), 5'b00001);
    chk("R1 chg", 32'(mode_chg), 0);
    chk("R1 irq", 32'(irq), 0);
    chk_stage("R1 R12 stage", 2'b01);
  endtask

  task automatic t_auto_path();
    ref_sel = 1; ref_qual = 1; any_qual = 1; step();
    chk("R4 pre", 32'(mode_code), 5'b00110);
    chk("R9 set", 32'(mode_chg), 1);
    chk_stage("R11 start", 2'b00);
    sec_tick = 1; step(); sec_tick = 0; step();
    chk_stage("R11 one tick", 2'b00);
    sec_tick = 1; step(); sec_tick = 0;
    chk_stage("R11 R12 acq after window", 2'b01);
    lock_ind = 1; step();
    chk("R6 locked", 32'(mode_code), 5'b00100);
    chk_stage("R12 lock stage", 2'b10);
    lock_ind = 0; step();
    chk("R7 lost", 32'(mode_code), 5'b00111);
    chk_stage("R11 lost acq", 2'b01);
    lock_ind = 1; step();
    chk("R7 relock", 32'(mode_code), 5'b00100);
    ref_switch = 1; step(); ref_switch = 0; lock_ind = 0;
    chk("R8 switch pre2", 32'(mode_code), 5'b00101);
    chk_stage("R13 window restarted", 2'b00);
    sec_tick = 1; step(); step(); sec_tick = 0;
    chk_stage("R13 window ends", 2'b01);
  endtask

  task automatic t_disqual();
    ref_qual = 0; any_qual = 0; lock_ind = 1; step(); lock_ind = 0;
    chk("R5 holdover", 32'(mode_code), 5'b00010);
    ref_qual = 1; any_qual = 1; step();
    chk("R8 hold reselect", 32'(mode_code), 5'b00101);
    lock_ind = 1; step(); lock_ind = 0;
    chk("R6 pre2 lock", 32'(mode_code), 5'b00100);
    step();
    chk("R7 lost again", 32'(mode_code), 5'b00111);
    ref_qual = 0; any_qual = 0; step();
    chk("R5 lost to hold", 32'(mode_code), 5'b00010);
    ref_qual = 1; any_qual = 1; ref_sel = 0; ref_switch = 1; step(); ref_switch = 0;
    chk("R8 hold switch", 32'(mode_code), 5'b00101);
    ref_sel = 1;
  endtask

  task automatic t_forced();
    logic [4:0] codes [7] = '{5'b00100, 5'b00111, 5'b00001, 5'b00010,
                              5'b00101, 5'b00110, 5'b01000};
    for (int i = 0; i < 7; i++) begin
      mode_ctrl = codes[i]; lock_ind = i[0]; ref_qual = i[1]; any_qual = i[1];
      step();
      chk("R2 forced", 32'(mode_code), 32'(codes[i]));
    end
    ref_qual = 1; any_qual = 1; lock_ind = 0;
  endtask

  task automatic t_reserved();
    mode_ctrl = 5'b01001; ref_switch = 1; lock_ind = 1; step();
    chk("R3 reserved a", 32'(mode_code), 5'b01000);
    mode_ctrl = 5'b11111; ref_sel = 0; step();
    chk("R3 reserved b", 32'(mode_code), 5'b01000);
    ref_switch = 0; lock_ind = 0; ref_sel = 1;
    mode_ctrl = 5'b00000; step();
    chk("R4 dco to pre", 32'(mode_code), 5'b00110);
  endtask

  task automatic t_irq();
    mode_ctrl = 5'b10000; chg_clr = 1; step(); chg_clr = 0;
    chk("R9 cleared", 32'(mode_chg), 0);
    irq_mask = 1; #1;
    chk("R10 no flag", 32'(irq), 0);
    mode_ctrl = 5'b00001; step();
    chk("R10 irq", 32'(irq), 1);
    irq_mask = 0; #1;
    chk("R10 masked", 32'(irq), 0);
    chg_clr = 1; mode_ctrl = 5'b00010; step(); chg_clr = 0;
    chk("R9 set wins", 32'(mode_chg), 1);
    mode_ctrl = 5'b10000; step();
    chk("R9 sticky holds", 32'(mode_chg), 1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_auto_path();
        t_disqual();
        t_forced();
        t_reserved();
        t_irq();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule